// File: doc/BRIEF.md
# Instruction word length pre-decoder

This block looks at a single 32-bit word taken from an instruction buffer and says, with no clock and no state, how many consecutive 32-bit words the instruction starting at that word occupies. A fetch-side parser places one copy on every buffer slot. It then chains the length results to find instruction boundaries without walking the buffer word by word.

The length comes from a five-bit routing field. That field is only meaningful inside the group of major opcodes that is allowed to carry constants. The field says whether the operands are short immediates held in the first word, or whether a 32-bit or 64-bit constant follows that word. It also carries two operand-negation requests, which the block passes on as flags. One major/minor combination encodes four stores. Each of these stores carries a displacement, sized by the routing field, and a store-data immediate as wide as the store. The length of such a store is the sum of both parts, limited by a parameter.

Top module: `ilen_predecode`

## Requirements
- R1: When `in_valid` is 0, `len_words` is 0 and every flag output (`const_present`, `const_wide`, `neg_src1`, `neg_src2`, `store_imm_disp`) is 0, and `store_size` is 0.
- R2: When `in_valid` is 1 and word bits 31:29 are not 3'b001, `len_words` is 1 and all flags and `store_size` are 0, whatever bits 15:11 hold.
- R3: For a valid word with bits 31:29 = 3'b001 that is not a store form and has bit 15 (constant-follows bit) = 0, `len_words` is 1 and `const_present` is 0.
- R4: For such a word with bit 15 = 1 and bit 12 (wide-constant bit) = 0, `len_words` is 2, `const_present` is 1 and `const_wide` is 0.
- R5: For such a word with bit 15 = 1 and bit 12 = 1, `len_words` is 3 and `const_wide` is 1; `const_wide` is never 1 while `const_present` is 0.
- R6: For a valid word with bits 31:29 = 3'b001, `neg_src1` equals bit 14 and `neg_src2` equals bit 13.
- R7: `store_imm_disp` is 1 exactly when the word is valid, bits 31:26 = 6'b001001 and bits 10:8 = 3'b011; `store_size` then equals bits 6:5 (0 byte, 1 half, 2 word, 3 doubleword), otherwise 0.
- R8: For a store form, `len_words` = (1, 2 or 3 from bits 15 and 12 as in R3..R5) + (2 if `store_size` is 3, else 1), limited to `MAX_LEN` (default 5).
- R9: The outputs follow a change of the inputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | The word on `in_word` holds a candidate instruction start |
| in_word | input | 32 | Buffer word to classify |
| len_words | output | 3 | Instruction length in 32-bit words (0 when not valid) |
| const_present | output | 1 | A constant follows the first word |
| const_wide | output | 1 | The following constant is 64 bits wide |
| neg_src1 | output | 1 | Negate source operand 1 |
| neg_src2 | output | 1 | Negate source operand 2 |
| store_imm_disp | output | 1 | Store form carrying both a displacement and a data immediate |
| store_size | output | 2 | Store data size code for the store form |

## Verification
The bench goes after the places where the constant-carrying group meets everything else. It sends words outside the group with every routing bit set, and a design that reads the routing field without gating it would report 2 or 3 words there. It sends store-major words whose minor bits are one value off 3'b011, where a loose minor compare would add a phantom immediate. It also sends a doubleword store with a 64-bit displacement, the largest sum, where a missing clamp or a mis-sized adder would wrap the length. Random words biased toward the store major and the constant group sit alongside these cases, and an invalid store word checks that every output is forced to zero.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

    localparam int WORD_W      = 32;
    localparam int MAJOR_LO    = 26;
    localparam int MAJOR_W     = 6;
    localparam int CLASS_W     = 3;
    localparam int MINOR_LO    = 5;
    localparam int MINOR_W     = 6;
    localparam int ROUTE_LO    = 11;
    localparam int ROUTE_W     = 5;

    localparam logic [CLASS_W-1:0] CONST_CLASS   = 3'b001;
    localparam logic [MAJOR_W-1:0] STORE_MAJOR   = 6'b001001;
    localparam logic [2:0]         STORE_MIN_TOP = 3'b011;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } st_size_e;

    // Routing field, most significant bit first.
    typedef struct packed {
        logic follows;   // a constant trails the first word
        logic neg1;
        logic neg2;
        logic wide;      // trailing constant is 64 bits
        logic sgn;
    } route_t;

    typedef struct packed {
        logic [MAJOR_W-1:0] major;
        logic [MINOR_W-1:0] minor;
        route_t             route;
    } fields_t;

    // Words consumed by the first word plus any trailing constant.
    function automatic int unsigned route_words(route_t r);
        if (!r.follows)   return 1;
        else if (r.wide)  return 3;
        else              return 2;
    endfunction

    // Words consumed by a store-data immediate: ceil(bits/32).
    function automatic int unsigned imm_words(st_size_e sz);
        return (sz == SZ_DOUBLE) ? 2 : 1;
    endfunction

endpackage

// File: rtl/ilen_fields.sv
module ilen_fields
    import ilen_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           fld,
    output logic              in_class
);
    logic unused_bits;

    always_comb begin
        fld.major = word[MAJOR_LO +: MAJOR_W];
        fld.minor = word[MINOR_LO +: MINOR_W];
        fld.route = route_t'(word[ROUTE_LO +: ROUTE_W]);
        in_class  = (word[WORD_W-1 -: CLASS_W] == CONST_CLASS);
    end

    assign unused_bits = ^{word[MAJOR_LO-1:ROUTE_LO+ROUTE_W], word[MINOR_LO-1:0]};

endmodule

// File: rtl/ilen_store.sv
module ilen_store
    import ilen_pkg::*;
(
    input  logic     valid,
    input  fields_t  fld,
    output logic     is_store,
    output st_size_e size
);
    always_comb begin
        is_store = valid
                && (fld.major == STORE_MAJOR)
                && (fld.minor[MINOR_W-1 -: 3] == STORE_MIN_TOP);
        size     = is_store ? st_size_e'(fld.minor[1:0]) : SZ_BYTE;
    end

    logic unused_minor;
    assign unused_minor = fld.minor[2];

endmodule

// File: rtl/ilen_sum.sv
module ilen_sum
    import ilen_pkg::*;
#(
    parameter int MAX_LEN = 5,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
)(
    input  logic             valid,
    input  logic             in_class,
    input  logic             is_store,
    input  route_t           route,
    input  st_size_e         size,
    output logic [LEN_W-1:0] len
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] CAP = SUM_W'(MAX_LEN);

    logic [SUM_W-1:0] base_w, extra_w, total_w;

    always_comb begin
        base_w  = SUM_W'(route_words(route));
        extra_w = is_store ? SUM_W'(imm_words(size)) : '0;
        total_w = base_w + extra_w;
        if (!valid)
            len = '0;
        else if (!in_class)
            len = LEN_W'(1);
        else if (total_w > CAP)
            len = LEN_W'(MAX_LEN);
        else
            len = total_w[LEN_W-1:0];
    end

    always_comb begin
        p_len_bound_r8: assert (len <= LEN_W'(MAX_LEN))
            else $error("length above limit");
    end

endmodule

// File: rtl/ilen_predecode.sv
module ilen_predecode
    import ilen_pkg::*;
#(
    parameter int MAX_LEN = 5,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
)(
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic [LEN_W-1:0]  len_words,
    output logic              const_present,
    output logic              const_wide,
    output logic              neg_src1,
    output logic              neg_src2,
    output logic              store_imm_disp,
    output logic [1:0]        store_size
);
    fields_t  fld;
    logic     in_class;
    logic     live;
    logic     is_store;
    st_size_e st_sz;

    ilen_fields u_fields (
        .word     (in_word),
        .fld      (fld),
        .in_class (in_class)
    );

    assign live = in_valid && in_class;

    ilen_store u_store (
        .valid    (in_valid),
        .fld      (fld),
        .is_store (is_store),
        .size     (st_sz)
    );

    ilen_sum #(.MAX_LEN(MAX_LEN)) u_sum (
        .valid    (in_valid),
        .in_class (in_class),
        .is_store (is_store),
        .route    (fld.route),
        .size     (st_sz),
        .len      (len_words)
    );

    always_comb begin
        const_present  = live && fld.route.follows;
        const_wide     = live && fld.route.follows && fld.route.wide;
        neg_src1       = live && fld.route.neg1;
        neg_src2       = live && fld.route.neg2;
        store_imm_disp = is_store;
        store_size     = st_sz;
    end

    logic unused_sgn;
    assign unused_sgn = fld.route.sgn;

    always_comb begin
        if (!in_valid) begin
            p_idle_quiet_r1: assert (len_words == '0 && !is_store && st_sz == SZ_BYTE)
                else $error("invalid word produced output");
        end
        if (in_valid && !in_class) begin
            p_outside_single_r2: assert (len_words == LEN_W'(1) && !is_store)
                else $error("non-constant opcode not single word");
        end
        p_wide_needs_const_r5: assert (!const_wide || const_present)
            else $error("wide constant without constant");
        p_store_in_group_r7: assert (!is_store || in_class)
            else $error("store form outside constant group");
        if (in_valid && in_class && !is_store) begin
            p_plain_len_r3: assert (len_words >= LEN_W'(1) && len_words <= LEN_W'(3))
                else $error("plain length out of range");
        end
    end

endmodule

// File: tb/ilen_predecode_bench.sv
module ilen_predecode_bench;

    logic        clk = 1'b0;
    logic        tb_valid = 1'b0;
    logic [31:0] tb_word = '0;
    logic [2:0]  len_words;
    logic        const_present, const_wide, neg_src1, neg_src2;
    logic        store_imm_disp;
    logic [1:0]  store_size;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ilen_predecode u_ilen_predecode (
        .in_valid       (tb_valid),
        .in_word        (tb_word),
        .len_words      (len_words),
        .const_present  (const_present),
        .const_wide     (const_wide),
        .neg_src1       (neg_src1),
        .neg_src2       (neg_src2),
        .store_imm_disp (store_imm_disp),
        .store_size     (store_size)
    );

    typedef struct {
        int len; int cp; int cw; int n1; int n2; int st; int sz;
        string tlen;
    } exp_t;

    function automatic exp_t model(logic v, logic [31:0] w);
        exp_t e;
        bit grp, st;
        int base;
        e = '{0, 0, 0, 0, 0, 0, 0, "R1"};
        if (!v) return e;
        grp = (w[31:29] == 3'b001);
        if (!grp) begin
            e.len = 1; e.tlen = "R2";
            return e;
        end
        st   = (w[31:26] == 6'b001001) && (w[10:8] == 3'b011);
        base = !w[15] ? 1 : (w[12] ? 3 : 2);
        e.cp = w[15];
        e.cw = w[15] & w[12];
        e.n1 = w[14];
        e.n2 = w[13];
        if (st) begin
            e.st = 1;
            e.sz = w[6:5];
            e.len = base + ((w[6:5] == 2'd3) ? 2 : 1);
            if (e.len > 5) e.len = 5;
            e.tlen = "R8";
        end else begin
            e.len = base;
            e.tlen = !w[15] ? "R3" : (w[12] ? "R5" : "R4");
        end
        return e;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (word %h valid %0d)",
                     tag, what, act, exp, tb_word, tb_valid);
        end
    endtask

    task automatic apply(logic v, logic [31:0] w);
        exp_t e;
        @(negedge clk);
        tb_valid = v;
        tb_word  = w;
        #1;
        e = model(v, w);
        chk(e.tlen, "len", int'(len_words), e.len);
        chk(e.tlen, "const_present", int'(const_present), e.cp);
        chk(e.tlen == "R4" ? "R4" : "R5", "const_wide", int'(const_wide), e.cw);
        chk(v ? "R6" : "R1", "neg_src1", int'(neg_src1), e.n1);
        chk(v ? "R6" : "R1", "neg_src2", int'(neg_src2), e.n2);
        chk("R7", "store_imm_disp", int'(store_imm_disp), e.st);
        chk("R7", "store_size", int'(store_size), e.sz);
    endtask

    initial begin
        void'($urandom(32'h5EED_1A7E));
        // R1: reset-like idle state, then an invalid store word
        apply(1'b0, 32'h0);
        apply(1'b0, 32'h2400_FB60);
        // R2: outside the group, every routing bit set
        apply(1'b1, 32'hE000_F800);
        apply(1'b1, 32'h4000_FFFF);
        // R3/R4/R5/R6: plain group words
        apply(1'b1, 32'h2000_0000);
        apply(1'b1, 32'h2000_E000);
        apply(1'b1, 32'h3C00_F000);
        // R7/R8: store forms, every size, smallest and largest sums
        apply(1'b1, 32'h2400_0300);
        apply(1'b1, 32'h2400_0320);
        apply(1'b1, 32'h2400_8340);
        apply(1'b1, 32'h2400_9360);
        // R7: minor off by one from the store pattern
        apply(1'b1, 32'h2400_9260);
        apply(1'b1, 32'h2400_9460);
        // R9: change input mid-cycle, outputs follow before the next edge
        @(posedge clk);
        #2;
        tb_valid = 1'b1;
        tb_word  = 32'h2400_9360;
        #1;
        chk("R9", "len mid-cycle", int'(len_words), 5);
        tb_word  = 32'h8000_0000;
        #1;
        chk("R9", "len mid-cycle", int'(len_words), 1);
        // Random words biased toward the constant group and store major
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int pick;
            w = $urandom;
            pick = $urandom_range(0, 3);
            if (pick == 1) w[31:29] = 3'b001;
            if (pick >= 2) begin
                w[31:26] = 6'b001001;
                if (pick == 3) w[10:8] = 3'b011;
            end
            apply(($urandom_range(0, 15) != 0), w);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule